// File: doc/BRIEF.md
# Vector Byte Shifter

This unit moves a whole 128-bit vector by a whole number of bytes, toward higher significance or toward lower significance, and fills the bytes it vacates with zeros. It is purely combinational and sits in the execute stage of a vector pipeline. The operand comes from the register file, and the result goes back to it. Two inputs from the decoded instruction control it: a direction bit and a 5-bit immediate.

Only the low four bits of the immediate set the distance in bytes, so any value from 0 to 31 maps onto a shift of 0 to 15 bytes. The top immediate bit has no effect. Inside the unit, the shift is a four-level logarithmic network with levels of 1, 2, 4 and 8 bytes. Each immediate bit enables one level.

Top module: `vec_byte_shifter`

## Requirements
- R1: With `dirRight` = 0 (left), result byte i equals source byte i−n for i ≥ n and is zero for i < n. Here n = `shiftImm[3:0]`, and byte i is bits 8i+7:8i.
- R2: With `dirRight` = 1 (right), result byte i equals source byte i+n for i+n ≤ 15 and is zero otherwise.
- R3: `shiftImm[4]` has no effect. Immediates v and v+16 give the same result for the same direction and source.
- R4: When `shiftImm[3:0]` is zero, the result equals the source in both directions.
- R5: When n ≥ 8, a left shift gives a result whose low 64 bits are zero, and a right shift gives a result whose high 64 bits are zero.
- R6: The direction encoding is 0 for left and 1 for right. With n = 1 and only byte 0 set, a left shift puts the value in byte 1 and a right shift gives all zeros.
- R7: A shift never adds set bits. The result holds no more ones than the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dirRight | input | 1 | Shift direction: 0 left (toward higher bytes), 1 right |
| shiftImm | input | 5 | Immediate; bits 3:0 give the byte distance, bit 4 ignored |
| srcVec | input | 128 | Source vector |
| resVec | output | 128 | Shifted vector |

## Verification
The checks in the checker module assume that the three inputs hold known values whenever the result is examined. They also assume that the result is read only after the combinational network has settled. The bench meets both conditions: it changes the inputs on the falling clock edge and reads the result a short delay later, always with fully defined vectors. Every immediate from 0 to 31 is applied in both directions to a set of fixed and pseudo-random vectors. Each result is compared with a byte-by-byte model in the bench.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  localparam int VEC_BYTES = 16;
  localparam int BYTE_W    = 8;
  localparam int VEC_W     = VEC_BYTES * BYTE_W;
  localparam int STAGE_CNT = $clog2(VEC_BYTES);
  localparam int IMM_W     = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic                 shiftLeft;
    logic [STAGE_CNT-1:0] stageEn;
  } vbs_ctrl_t;
endpackage

// File: rtl/vbs_control.sv
module vbs_control
  import vbs_pkg::*;
(
  input  logic             dirRight,
  input  logic [IMM_W-1:0] shiftImm,
  output vbs_ctrl_t        ctrl
);
  // upper immediate bits alias back into the 0..15 range
  logic unusedAlias;
  assign unusedAlias = ^shiftImm[IMM_W-1:STAGE_CNT];

  always_comb begin
    ctrl.shiftLeft = ~dirRight;
    ctrl.stageEn   = shiftImm[STAGE_CNT-1:0];
  end
endmodule

// File: rtl/vbs_datapath.sv
module vbs_datapath
  import vbs_pkg::*;
(
  input  vbs_ctrl_t        ctrl,
  input  logic [VEC_W-1:0] srcVec,
  output logic [VEC_W-1:0] resVec
);
  logic [VEC_W-1:0] stageVal [STAGE_CNT+1];

  assign stageVal[0] = srcVec;

  for (genvar s = 0; s < STAGE_CNT; s++) begin : g_stage
    localparam int SH_BITS = BYTE_W << s;
    logic [VEC_W-1:0] leftVal;
    logic [VEC_W-1:0] rightVal;
    assign leftVal  = stageVal[s] << SH_BITS;
    assign rightVal = stageVal[s] >> SH_BITS;
    assign stageVal[s+1] = !ctrl.stageEn[s] ? stageVal[s] :
                           (ctrl.shiftLeft ? leftVal : rightVal);
  end

  assign resVec = stageVal[STAGE_CNT];
endmodule

// File: rtl/vec_byte_shifter.sv
module vec_byte_shifter
  import vbs_pkg::*;
(
  input  logic               dirRight,
  input  logic [IMM_W-1:0]   shiftImm,
  input  logic [VEC_W-1:0]   srcVec,
  output logic [VEC_W-1:0]   resVec
);
  vbs_ctrl_t ctrl;

  vbs_control u_ctrl (
    .dirRight (dirRight),
    .shiftImm (shiftImm),
    .ctrl     (ctrl)
  );

  vbs_datapath u_dp (
    .ctrl   (ctrl),
    .srcVec (srcVec),
    .resVec (resVec)
  );
endmodule

// File: rtl/vbs_checker.sv
module vbs_checker
  import vbs_pkg::*;
(
  input logic             dirRight,
  input logic [IMM_W-1:0] shiftImm,
  input logic [VEC_W-1:0] srcVec,
  input logic [VEC_W-1:0] resVec
);
  always_comb begin
    // R4
    zero_dist_chk: assert (shiftImm[3:0] != 4'd0 || resVec == srcVec);
    // R1
    left_low_byte_chk: assert (dirRight || shiftImm[3:0] == 4'd0 || resVec[7:0] == 8'd0);
    // R2
    right_top_byte_chk: assert (!dirRight || shiftImm[3:0] == 4'd0 || resVec[VEC_W-1 -: 8] == 8'd0);
    // R5
    left_half_chk: assert (dirRight || !shiftImm[3] || resVec[VEC_W/2-1:0] == '0);
    // R5
    right_half_chk: assert (!dirRight || !shiftImm[3] || resVec[VEC_W-1:VEC_W/2] == '0);
    // R7
    no_new_ones_chk: assert ($countones(resVec) <= $countones(srcVec));
  end
endmodule

bind vec_byte_shifter vbs_checker u_chk (
  .dirRight (dirRight),
  .shiftImm (shiftImm),
  .srcVec   (srcVec),
  .resVec   (resVec)
);

// File: tb/vec_byte_shifter_bench.sv
module vec_byte_shifter_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         dirRight;
  logic [4:0]   shiftImm;
  logic [127:0] srcVec;
  logic [127:0] resVec;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vec_byte_shifter u_vec_byte_shifter (
    .dirRight (dirRight),
    .shiftImm (shiftImm),
    .srcVec   (srcVec),
    .resVec   (resVec)
  );

  function automatic logic [127:0] model(bit right, logic [4:0] imm, logic [127:0] s);
    logic [127:0] e = '0;
    int n = int'(imm[3:0]);
    for (int i = 0; i < 16; i++) begin
      if (!right && i >= n)      e[i*8 +: 8] = s[(i-n)*8 +: 8];
      if (right && i + n <= 15)  e[i*8 +: 8] = s[(i+n)*8 +: 8];
    end
    return e;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(bit right, logic [4:0] imm, logic [127:0] s);
    @(negedge clk);
    dirRight = right;
    shiftImm = imm;
    srcVec   = s;
    #1;
  endtask

  task automatic sweep(logic [127:0] s);
    for (int d = 0; d < 2; d++) begin
      for (int v = 0; v < 32; v++) begin
        logic [127:0] exp;
        apply(d[0], v[4:0], s);
        exp = model(d[0], v[4:0], s);
        if (v[3:0] == 4'd0)      check("R4 zero distance", resVec, s);
        else if (v >= 16)        check("R3 alias of bit4", resVec, model(d[0], v[4:0] - 5'd16, s));
        else if (d == 0)         check("R1 left shift", resVec, exp);
        else                     check("R2 right shift", resVec, exp);
        if (v[3]) begin
          if (d == 0) check("R5 left low half zero", {64'd0, resVec[63:0]}, 128'd0);
          else        check("R5 right high half zero", {resVec[127:64], 64'd0}, 128'd0);
        end
        total++;
        if ($countones(resVec) > $countones(s)) begin
          bad++;
          $display("FAIL R7 ones act=%0d exp<=%0d", $countones(resVec), $countones(s));
        end
      end
    end
  endtask

  initial begin
    dirRight = 1'b0;
    shiftImm = 5'd0;
    srcVec   = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // quiet state: zero in gives zero out
    apply(1'b0, 5'd7, 128'd0);
    check("R1 zero source", resVec, 128'd0);
    // R6 direction encoding
    apply(1'b0, 5'd1, 128'hA5);
    check("R6 left moves up", resVec, 128'hA500);
    apply(1'b1, 5'd1, 128'hA5);
    check("R6 right drops byte", resVec, 128'd0);
    // R1 R2 boundary: distance 15
    apply(1'b0, 5'd15, 128'h0123456789ABCDEF_FEDCBA9876543210);
    check("R1 max distance", resVec, {8'h10, 120'd0});
    apply(1'b1, 5'd31, 128'h0123456789ABCDEF_FEDCBA9876543210);
    check("R2 R3 max distance aliased", resVec, 128'h01);
    sweep({128{1'b1}});
    sweep(128'h0F1E2D3C4B5A6978_8796A5B4C3D2E1F0);
    for (int k = 0; k < 6; k++)
      sweep({$urandom(), $urandom(), $urandom(), $urandom()});
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule